// File: doc/BRIEF.md
# Edge-Sensitive External Interrupt Port

This peripheral watches seven external interrupt pins, numbered 1 to 7, and turns their activity into interrupt requests for a system interrupt controller. Each pin has its own trigger mode. In level mode the pin is active low and its request follows the pin. In the three edge modes (rising, falling, both) a detected edge sets a sticky flag that software clears by writing a one to it. Each pin also has a direction bit, an output data bit and an enable bit that masks its request. A readback register shows the synchronised pin levels.

Software reaches the registers through a simple register bus with read and write strobes and a halfword/byte size select. Reads are combinational in the cycle of the strobe. This bus carries no data stream, so it has no valid/ready handshake: a strobe is always accepted in its own cycle, and no back-pressure exists. Index 0 is reserved in every per-pin register and in the trigger-mode register (bits 1:0). It always reads as zero and never drives a pin or a request.

Top module: `edge_irq_port`

## Requirements
- R1: Position 0 is reserved in every per-pin register and in the trigger-mode register. Writes to it are dropped, it reads as 0, and it drives no output.
- R2: The trigger-mode register holds a 2-bit field for pin n at bits 2n+1:2n. 00 selects level (active low), 01 rising edge, 10 falling edge, 11 both edges.
- R3: The register offsets are: trigger mode (16 bits) at 0, direction at 2, enable at 3, output data at 4, pin readback at 5, flags at 6. A halfword access (bus_half=1) is valid only at offset 0 and is ignored elsewhere. A byte write uses bus_wdata[7:0]. A byte write to offset 0 updates only bits 15:8 of the trigger-mode register, and one to offset 1 updates only bits 7:0. A byte read returns its data in bus_rdata[7:0] with the upper bits at 0. bus_rdata is 0 when bus_rd is low.
- R4: pin_oe[n] equals direction bit n (1 = output) and pin_out[n] equals output-data bit n.
- R5: irq_req[n] = flag[n] AND enable[n].
- R6: Writing 1 to a flag bit clears that flag in edge modes. Writing 0 leaves it unchanged.
- R7: Each pin passes through a two-flop synchroniser that resets to 1. The readback register shows the synchronised value, which reflects a pin change two clocks after it is captured.
- R8: In an edge mode, a matching edge at a pin driven just before clock edge k sets the flag at clock edge k+2. If a clear write falls in the cycle where the edge is detected, the flag still sets.
- R9: In level mode the flag equals the inverse of the synchronised pin, one clock later. A clear write has no lasting effect while the pin is low.
- R10: After reset, the trigger-mode, direction, enable, output-data and flag registers are all 0, and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_half | input | 1 | 1 = halfword access, 0 = byte access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the strobe cycle |
| pin_in | input | 7 | External pin levels, pins 7..1 |
| pin_oe | output | 7 | Output enable per pin |
| pin_out | output | 7 | Output data per pin |
| irq_req | output | 7 | Interrupt request per pin |

## Verification
The flag assertions assume that the trigger-mode field of a pin is treated as constant across the one clock each property spans. The stimulus changes modes only through bus writes, which take effect at a clock edge, so each property sees the mode it was triggered under. The assertions also assume that pins may change in any cycle but only settle at clock edges, as a synchroniser delivers them. The bench changes pins and bus strobes only on falling clock edges, and it lines up clear writes at every offset around a detected edge, including the cycle of detection.

// File: rtl/eport_pkg.sv
package eport_pkg;
  typedef enum logic [1:0] {
    TRIG_LEVEL = 2'b00,
    TRIG_RISE  = 2'b01,
    TRIG_FALL  = 2'b10,
    TRIG_BOTH  = 2'b11
  } trig_e;

  localparam logic [2:0] OFS_MODE_HI = 3'h0;
  localparam logic [2:0] OFS_MODE_LO = 3'h1;
  localparam logic [2:0] OFS_DIR     = 3'h2;
  localparam logic [2:0] OFS_IEN     = 3'h3;
  localparam logic [2:0] OFS_ODAT    = 3'h4;
  localparam logic [2:0] OFS_PIN     = 3'h5;
  localparam logic [2:0] OFS_FLAG    = 3'h6;
endpackage

// File: rtl/eport_sync.sv
module eport_sync #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      q      <= '1;
      q_prev <= '1;
    end else begin
      meta_q <= d;
      q      <= meta_q;
      q_prev <= q;
    end
  end
endmodule

// File: rtl/eport_flag_cell.sv
module eport_flag_cell
  import eport_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       cur,
  input  logic       prev,
  input  logic       clr,
  output logic       flag
);
  logic rise, fall, evt, is_edge;

  assign rise    = cur & ~prev;
  assign fall    = ~cur & prev;
  assign is_edge = (trig_e'(mode) != TRIG_LEVEL);

  always_comb begin
    case (trig_e'(mode))
      TRIG_RISE: evt = rise;
      TRIG_FALL: evt = fall;
      TRIG_BOTH: evt = rise | fall;
      default:   evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (!is_edge) flag <= ~cur;
    else if (evt)      flag <= 1'b1;
    else if (clr)      flag <= 1'b0;
  end

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_edge && evt) |=> flag);
  // R8
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_edge && !evt && !clr && !flag) |=> !flag);
  // R6
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_edge && clr && !evt) |=> !flag);
  // R9
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_edge) |=> (flag == !$past(cur)));
endmodule

// File: rtl/eport_regs.sv
module eport_regs
  import eport_pkg::*;
#(
  parameter int unsigned NPIN = 7,
  localparam int unsigned VW  = NPIN + 1,
  localparam int unsigned DW  = 2 * VW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          hw,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [NPIN:1] pin_sync,
  input  logic [NPIN:1] flags,
  output logic [DW-1:2] mode_q,
  output logic [NPIN:1] dir_q,
  output logic [NPIN:1] ien_q,
  output logic [NPIN:1] odat_q,
  output logic [NPIN:1] clr
);
  logic byte_wr, full_wr;
  logic unused_bits;

  assign byte_wr = wr_en & ~hw;
  assign full_wr = wr_en & hw & (addr == OFS_MODE_HI);
  assign unused_bits = ^{wdata[0], wdata[1]};
  assign clr = (byte_wr && addr == OFS_FLAG) ? wdata[NPIN:1] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      dir_q  <= '0;
      ien_q  <= '0;
      odat_q <= '0;
    end else if (full_wr) begin
      mode_q <= wdata[DW-1:2];
    end else if (byte_wr) begin
      case (addr)
        OFS_MODE_HI: mode_q[DW-1:VW] <= wdata[VW-1:0];
        OFS_MODE_LO: mode_q[VW-1:2]  <= wdata[VW-1:2];
        OFS_DIR:     dir_q           <= wdata[NPIN:1];
        OFS_IEN:     ien_q           <= wdata[NPIN:1];
        OFS_ODAT:    odat_q          <= wdata[NPIN:1];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (hw) begin
        if (addr == OFS_MODE_HI) rdata = {mode_q, 2'b00};
      end else begin
        case (addr)
          OFS_MODE_HI: rdata = DW'(mode_q[DW-1:VW]);
          OFS_MODE_LO: rdata = DW'({mode_q[VW-1:2], 2'b00});
          OFS_DIR:     rdata = DW'({dir_q, 1'b0});
          OFS_IEN:     rdata = DW'({ien_q, 1'b0});
          OFS_ODAT:    rdata = DW'({odat_q, 1'b0});
          OFS_PIN:     rdata = DW'({pin_sync, 1'b0});
          OFS_FLAG:    rdata = DW'({flags, 1'b0});
          default:     rdata = '0;
        endcase
      end
    end
  end

  // R3
  half_misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hw && addr != OFS_MODE_HI) |=>
      ($stable(mode_q) && $stable(dir_q) && $stable(ien_q) && $stable(odat_q)));
  // R3
  byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_wr && addr == OFS_MODE_LO) |=> $stable(mode_q[DW-1:VW]));
endmodule

// File: rtl/edge_irq_port.sv
module edge_irq_port #(
  parameter int unsigned NPIN = 7,
  localparam int unsigned DW  = 2 * (NPIN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic          bus_half,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [NPIN:1] pin_in,
  output logic [NPIN:1] pin_oe,
  output logic [NPIN:1] pin_out,
  output logic [NPIN:1] irq_req
);
  logic [NPIN:1] cur, prev, clr, flags, dir_q, ien_q, odat_q;
  logic [DW-1:2] mode_q;

  eport_sync #(.W(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(cur), .q_prev(prev)
  );

  eport_regs #(.NPIN(NPIN)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr_en(bus_wr), .rd_en(bus_rd),
    .hw(bus_half), .wdata(bus_wdata), .rdata(bus_rdata), .pin_sync(cur),
    .flags(flags), .mode_q(mode_q), .dir_q(dir_q), .ien_q(ien_q),
    .odat_q(odat_q), .clr(clr)
  );

  for (genvar n = 1; n <= NPIN; n++) begin : g_pin
    eport_flag_cell u_cell (
      .clk(clk), .rst_n(rst_n), .mode(mode_q[2*n+1:2*n]), .cur(cur[n]),
      .prev(prev[n]), .clr(clr[n]), .flag(flags[n])
    );
  end

  assign irq_req = flags & ien_q;
  assign pin_oe  = dir_q;
  assign pin_out = odat_q;
endmodule

// File: tb/test_edge_irq_port.sv
module test_edge_irq_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0, half = 1'b0;
  logic [15:0] wdata = '0;
  logic [7:1]  pin = 7'h7f;
  wire  [15:0] rdata;
  wire  [7:1]  oe, pout, irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  string cur_req = "R10";

  always #10 clk = ~clk;

  edge_irq_port i_edge_irq_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
    .bus_half(half), .bus_wdata(wdata), .bus_rdata(rdata), .pin_in(pin),
    .pin_oe(oe), .pin_out(pout), .irq_req(irq)
  );

  // Behavioural reference model
  logic [7:0]  m_s1, m_s2, m_s3, m_dir, m_en, m_out, m_flag, m_clr;
  logic [15:0] m_par;

  function automatic logic next_flag(logic [1:0] md, logic c, logic p, logic cl, logic old);
    logic r, f, e;
    if (md == 2'b00) return !c;
    r = c && !p;
    f = !c && p;
    e = (md == 2'b01) ? r : (md == 2'b10) ? f : (r || f);
    if (e) return 1'b1;
    if (cl) return 1'b0;
    return old;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '1; m_s2 = '1; m_s3 = '1;
      m_dir = '0; m_en = '0; m_out = '0; m_flag = '0; m_par = '0;
    end else begin
      m_clr = (wr && !half && addr == 3'd6) ? wdata[7:0] : 8'h00;
      for (int n = 1; n < 8; n++)
        m_flag[n] = next_flag(m_par[2*n +: 2], m_s2[n], m_s3[n], m_clr[n], m_flag[n]);
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = {pin, 1'b1};
      if (wr) begin
        if (half) begin
          if (addr == 3'd0) m_par = wdata & 16'hFFFC;
        end else begin
          case (addr)
            3'd0: m_par[15:8] = wdata[7:0];
            3'd1: m_par[7:0]  = wdata[7:0] & 8'hFC;
            3'd2: m_dir = wdata[7:0] & 8'hFE;
            3'd3: m_en  = wdata[7:0] & 8'hFE;
            3'd4: m_out = wdata[7:0] & 8'hFE;
            default: ;
          endcase
        end
      end
    end
  end

  function automatic logic [15:0] exp_rdata();
    if (!rd) return 16'h0;
    if (half) return (addr == 3'd0) ? m_par : 16'h0;
    case (addr)
      3'd0: return {8'h00, m_par[15:8]};
      3'd1: return {8'h00, m_par[7:0]};
      3'd2: return {8'h00, m_dir};
      3'd3: return {8'h00, m_en};
      3'd4: return {8'h00, m_out};
      3'd5: return {8'h00, m_s2[7:1], 1'b0};
      3'd6: return {8'h00, m_flag[7:1], 1'b0};
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // Compare every cycle, 2 ns before the rising edge
  initial begin
    forever begin
      @(negedge clk);
      #8;
      if (!done) begin
        chk(cur_req, {9'h0, irq}, {9'h0, m_flag[7:1] & m_en[7:1]});
        chk("R4", {9'h0, oe}, {9'h0, m_dir[7:1]});
        chk("R4", {9'h0, pout}, {9'h0, m_out[7:1]});
        chk(cur_req, rdata, exp_rdata());
      end
    end
  end

  task automatic wr8(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; half = 1'b0; wdata = {8'h00, d}; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask
  task automatic wr16(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; half = 1'b1; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0; half = 1'b0;
  endtask
  task automatic rd8(input logic [2:0] a);
    @(negedge clk); addr = a; half = 1'b0; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask
  task automatic rd16(input logic [2:0] a);
    @(negedge clk); addr = a; half = 1'b1; rd = 1'b1;
    @(negedge clk); rd = 1'b0; half = 1'b0;
  endtask
  task automatic setpin(input int n, input logic v);
    @(negedge clk); pin[n] = v;
  endtask
  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R10: reset state
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    for (int a = 0; a < 7; a++) rd8(3'(a));
    rd16(0);
    // R3: offsets, byte lanes, halfword alignment
    cur_req = "R3";
    wr16(0, 16'h1234); rd16(0);
    wr8(1, 8'hAB); rd16(0); rd8(1);
    wr8(0, 8'h5C); rd16(0); rd8(0);
    wr16(2, 16'hFFFF); rd8(2); rd8(3); rd16(2);
    wr16(0, 16'h0000);
    // R1: reserved position 0
    cur_req = "R1";
    wr8(2, 8'h01); wr8(3, 8'h01); wr8(4, 8'h01); wr8(1, 8'h03);
    rd8(2); rd8(3); rd8(4); rd8(1); rd16(0);
    // R4: direction and output data
    cur_req = "R4";
    wr8(2, 8'hFF); wr8(4, 8'h54); rd8(2); rd8(4); idle(2);
    wr8(2, 8'h00); wr8(4, 8'h00);
    // R2: pin1 rising, pin2 falling, pin3 both, pin4 level
    cur_req = "R2";
    wr16(0, 16'h00E4); wr8(3, 8'hFE);
    for (int p = 1; p <= 4; p++) begin
      setpin(p, 1'b0); idle(4); rd8(6);
      setpin(p, 1'b1); idle(4); rd8(6);
      cur_req = "R6";
      wr8(6, 8'hFE); idle(3); rd8(6);
      cur_req = "R2";
    end
    // R8: clear write placed at every offset around an edge
    cur_req = "R8";
    for (int d = 0; d < 5; d++) begin
      @(negedge clk); pin[3] = ~pin[3];
      idle(d); wr8(6, 8'h08); idle(4); rd8(6);
      wr8(6, 8'h08); idle(2);
    end
    // R9: level mode ignores clear while low
    cur_req = "R9";
    setpin(4, 1'b0); idle(4); wr8(6, 8'h10); idle(2); rd8(6);
    setpin(4, 1'b1); idle(4); rd8(6);
    // R5: enable masking
    cur_req = "R5";
    setpin(1, 1'b0); setpin(1, 1'b1); idle(4);
    wr8(3, 8'h00); idle(2); wr8(3, 8'h02); idle(2); wr8(6, 8'hFE);
    // R7: synchronised readback
    cur_req = "R7";
    @(negedge clk); pin = 7'h2A; rd8(5); rd8(5); idle(1); rd8(5);
    @(negedge clk); pin = 7'h55; idle(3); rd8(5);
    // R5: random traffic
    cur_req = "R5";
    for (int i = 0; i < 3000; i++) begin
      int sel;
      sel = int'($urandom_range(0, 5));
      case (sel)
        0: begin @(negedge clk); pin = 7'($urandom); end
        1: wr8(3'($urandom_range(0, 7)), 8'($urandom));
        2: wr16(3'($urandom_range(0, 2)), 16'($urandom));
        3: rd8(3'($urandom_range(0, 7)));
        4: rd16(3'($urandom_range(0, 2)));
        default: wr8(6, 8'($urandom));
      endcase
    end
    idle(4);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule